// File: doc/BRIEF.md
# Write-Only Two-Wire Bus Receiver with Clock Holding

This block is the bus front end of a display-driver style peripheral. It listens to an open-drain two-wire serial bus (SCL and SDA), finds START and STOP conditions, and compares each address byte with a fixed 7-bit address. The last bit of that address comes from a select strap, so two copies of the peripheral can share one bus. A matching write address is acknowledged. Every data byte that follows is acknowledged too. Each byte goes downstream on an 8-bit output, marked by a one-cycle valid strobe and by a flag that picks out the first byte after the address.

The block only ever receives. It never starts a transfer and never returns data. It drives SDA only to acknowledge. Downstream logic that has not finished with the previous byte raises `busy`. The block then holds SCL low in the low phase that follows the acknowledge clock, and lets it go once `busy` drops, so no byte is lost. A 3-bit subaddress strap is passed through for the downstream command logic.

Top module: `i2cw_slave`

## Requirements
- R1: After reset, `sdaPullDown`, `sclPullDown`, `rxValid` and `rxFirst` are all 0.
- R2: An address byte whose upper seven bits equal 0111000 with bit 0 replaced by `selStrap`, and whose eighth bit (R/W, sent last) is 0, is acknowledged by asserting `sdaPullDown` across the ninth SCL clock.
- R3: An address byte whose seven address bits do not match gets no acknowledge. Later bytes up to the next START give no acknowledge and no `rxValid`.
- R4: A matching address with R/W bit equal to 1 (read) gets no acknowledge and is ignored until the next START.
- R5: After a matched write address, each data byte is acknowledged. It appears on `rxData` with the first bit on the bus in bit 7, together with an `rxValid` pulse exactly one clock long.
- R6: `rxFirst` is 1 alongside `rxValid` for the first data byte after an acknowledged address, and 0 for every later byte.
- R7: If `busy` is 1 when SCL falls at the end of the acknowledge clock, `sclPullDown` rises and stays 1 until `busy` is 0. The next byte is then received intact.
- R8: A repeated START (SDA falling while SCL is high, with no STOP before it) restarts address reception, whatever state the block is in.
- R9: After a STOP (SDA rising while SCL is high), clocked bits give no acknowledge and no `rxValid` until a START is seen.
- R10: `subAddr` always equals `subAddrStrap`.
- R11: `sdaPullDown` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Sensed level of the SCL line |
| sdaIn | input | 1 | Sensed level of the SDA line |
| selStrap | input | 1 | Strap giving bit 0 of the slave address |
| subAddrStrap | input | 3 | Hardware subaddress strap |
| busy | input | 1 | Downstream logic cannot yet take another byte |
| sclPullDown | output | 1 | Pull SCL low (clock hold) |
| sdaPullDown | output | 1 | Pull SDA low (acknowledge) |
| rxData | output | 8 | Last received data byte |
| rxValid | output | 1 | One-cycle strobe: `rxData` holds a new byte |
| rxFirst | output | 1 | Strobed byte is the first after the address |
| subAddr | output | 3 | Subaddress for downstream command logic |

## Verification
The hardest case to reach is the clock hold. It needs `busy` to be high at the exact SCL fall that ends an acknowledge clock, and the master model must really wait on the wired-AND SCL line rather than on its own clock. The bench builds the open-drain bus from the master's drives and the block's pull-downs. It raises `busy` before a data byte and checks that SCL stays low while `busy` is held for many cycles. After `busy` drops, it sends another byte and checks that the byte arrives intact. Repeated START is exercised both out of an ignored transfer and out of an active one.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_ACK,
    ST_HOLD,
    ST_SKIP
  } busStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic clrBits;
    logic shiftEn;
    logic loadOut;
    logic markFirst;
  } dpCtrlT;

  // observations from datapath to control
  typedef struct packed {
    logic startSeen;
    logic stopSeen;
    logic sclRise;
    logic sclFall;
    logic byteDone;
    logic lastBit;
    logic addrHit;
    logic sclLevel;
  } dpStatT;

endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '1;
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/i2cw_datapath.sv
module i2cw_datapath
  import i2cw_pkg::*;
#(
  parameter int             BYTE_W      = 8,
  parameter int             ADDR_W      = 7,
  parameter logic [ADDR_W-1:0] ADDR_BASE = 7'b0111000,
  parameter int             SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              selStrap,
  input  dpCtrlT            ctrl,
  output dpStatT            stat,
  output logic [BYTE_W-1:0] rxData,
  output logic              rxValid,
  output logic              rxFirst
);

  localparam int CNT_W   = $clog2(BYTE_W + 1);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] rawLines;
  logic [N_LINES-1:0] syncLines;
  logic sclS, sdaS, sclD, sdaD;
  logic [BYTE_W-1:0] shiftReg;
  logic [CNT_W-1:0]  bitCnt;
  logic              firstPend;
  logic [ADDR_W-1:0] ownAddr;

  assign rawLines = {sclIn, sdaIn};

  genvar g;
  generate
    for (g = 0; g < N_LINES; g++) begin : gen_sync
      i2cw_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rstN(rstN),
        .d   (rawLines[g]),
        .q   (syncLines[g])
      );
    end
  endgenerate

  assign sclS = syncLines[1];
  assign sdaS = syncLines[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclS;
      sdaD <= sdaS;
    end
  end

  // bit counter and shift register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      shiftReg <= '0;
    end else if (ctrl.clrBits) begin
      bitCnt <= '0;
    end else if (ctrl.shiftEn) begin
      bitCnt   <= bitCnt + CNT_W'(1);
      shiftReg <= {shiftReg[BYTE_W-2:0], sdaS};
    end
  end

  // output byte, strobe and first-byte flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData    <= '0;
      rxValid   <= 1'b0;
      rxFirst   <= 1'b0;
      firstPend <= 1'b0;
    end else begin
      rxValid <= ctrl.loadOut;
      rxFirst <= ctrl.loadOut & firstPend;
      if (ctrl.loadOut) begin
        rxData    <= {shiftReg[BYTE_W-2:0], sdaS};
        firstPend <= 1'b0;
      end else if (ctrl.markFirst) begin
        firstPend <= 1'b1;
      end
    end
  end

  assign ownAddr = {ADDR_BASE[ADDR_W-1:1], selStrap};

  always_comb begin
    stat.startSeen = sclS & sclD & sdaD & ~sdaS;
    stat.stopSeen  = sclS & sclD & ~sdaD & sdaS;
    stat.sclRise   = sclS & ~sclD;
    stat.sclFall   = ~sclS & sclD;
    stat.byteDone  = (bitCnt == CNT_W'(BYTE_W));
    stat.lastBit   = (bitCnt == CNT_W'(BYTE_W - 1));
    stat.addrHit   = (shiftReg[BYTE_W-1 -: ADDR_W] == ownAddr) & ~shiftReg[0];
    stat.sclLevel  = sclS;
  end

  // R5: a byte strobe never lasts more than one cycle
  assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R6: first-byte flag only travels with a strobe
  assert_first_with_valid_R6: assert property (@(posedge clk) disable iff (!rstN)
    rxFirst |-> rxValid);

  // R5: bit counter never passes a full byte
  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(BYTE_W));

endmodule

// File: rtl/i2cw_control.sv
module i2cw_control
  import i2cw_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  dpStatT stat,
  input  logic   busy,
  output dpCtrlT ctrl,
  output logic   sdaPullDown,
  output logic   sclPullDown
);

  busStateT state, nextState;

  always_comb begin
    ctrl      = '0;
    nextState = state;
    if (stat.startSeen) begin
      nextState    = ST_ADDR;
      ctrl.clrBits = 1'b1;
    end else if (stat.stopSeen) begin
      nextState = ST_IDLE;
    end else begin
      case (state)
        ST_ADDR: begin
          if (stat.sclRise && !stat.byteDone) begin
            ctrl.shiftEn = 1'b1;
          end else if (stat.sclFall && stat.byteDone) begin
            if (stat.addrHit) begin
              nextState      = ST_ACK;
              ctrl.markFirst = 1'b1;
            end else begin
              nextState = ST_SKIP;
            end
          end
        end
        ST_DATA: begin
          if (stat.sclRise && !stat.byteDone) begin
            ctrl.shiftEn = 1'b1;
            ctrl.loadOut = stat.lastBit;
          end else if (stat.sclFall && stat.byteDone) begin
            nextState = ST_ACK;
          end
        end
        ST_ACK: begin
          if (stat.sclFall) begin
            ctrl.clrBits = 1'b1;
            nextState    = busy ? ST_HOLD : ST_DATA;
          end
        end
        ST_HOLD: begin
          if (!busy) nextState = ST_DATA;
        end
        default: nextState = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      sdaPullDown <= 1'b0;
      sclPullDown <= 1'b0;
    end else begin
      state       <= nextState;
      sdaPullDown <= (nextState == ST_ACK);
      sclPullDown <= (nextState == ST_HOLD);
    end
  end

  // R11: acknowledge drive starts only while SCL is low
  assert_ack_rise_low_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullDown) |-> !stat.sclLevel);

  // R11: acknowledge drive ends only while SCL is low
  assert_ack_fall_low_R11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaPullDown) |-> !stat.sclLevel);

  // R7: clock hold begins straight after an acknowledge
  assert_hold_after_ack_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclPullDown) |-> $past(sdaPullDown));

  // R7: clock hold released only once busy has dropped
  assert_hold_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclPullDown) |-> $past(!busy));

endmodule

// File: rtl/i2cw_slave.sv
module i2cw_slave
  import i2cw_pkg::*;
#(
  parameter int                BYTE_W      = 8,
  parameter int                ADDR_W      = 7,
  parameter logic [ADDR_W-1:0] ADDR_BASE   = 7'b0111000,
  parameter int                SUB_W       = 3,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              selStrap,
  input  logic [SUB_W-1:0]  subAddrStrap,
  input  logic              busy,
  output logic              sclPullDown,
  output logic              sdaPullDown,
  output logic [BYTE_W-1:0] rxData,
  output logic              rxValid,
  output logic              rxFirst,
  output logic [SUB_W-1:0]  subAddr
);

  dpCtrlT ctrl;
  dpStatT stat;

  i2cw_datapath #(
    .BYTE_W     (BYTE_W),
    .ADDR_W     (ADDR_W),
    .ADDR_BASE  (ADDR_BASE),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .sclIn   (sclIn),
    .sdaIn   (sdaIn),
    .selStrap(selStrap),
    .ctrl    (ctrl),
    .stat    (stat),
    .rxData  (rxData),
    .rxValid (rxValid),
    .rxFirst (rxFirst)
  );

  i2cw_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .stat       (stat),
    .busy       (busy),
    .ctrl       (ctrl),
    .sdaPullDown(sdaPullDown),
    .sclPullDown(sclPullDown)
  );

  // R10: subaddress strap forwarded for downstream command logic
  assign subAddr = subAddrStrap;

endmodule

// File: tb/i2cw_slave_tb.sv
module i2cw_slave_tb;

  localparam int HALF = 20;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic selStrap = 1'b0;
  logic [2:0] subAddrStrap = 3'b101;
  logic busy = 1'b0;
  logic sclPullDown, sdaPullDown, rxValid, rxFirst;
  logic [7:0] rxData;
  logic [2:0] subAddr;
  logic sclLine, sdaLine;

  int checks = 0, fails = 0;
  logic [7:0] gotData [0:63];
  logic       gotFirst[0:63];
  int gotCount = 0;
  int maxWidth = 0, curWidth = 0;
  int sdaBadChanges = 0;
  logic prevSdaPd = 1'b0;
  logic finished = 1'b0;

  always #2 clk = ~clk;

  assign sclLine = sclM & ~sclPullDown;
  assign sdaLine = sdaM & ~sdaPullDown;

  i2cw_slave u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaLine),
    .selStrap(selStrap), .subAddrStrap(subAddrStrap), .busy(busy),
    .sclPullDown(sclPullDown), .sdaPullDown(sdaPullDown),
    .rxData(rxData), .rxValid(rxValid), .rxFirst(rxFirst), .subAddr(subAddr)
  );

  // passive monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      if (rxValid) begin
        if (gotCount < 64) begin
          gotData[gotCount]  <= rxData;
          gotFirst[gotCount] <= rxFirst;
        end
        gotCount <= gotCount + 1;
        curWidth <= curWidth + 1;
        if (curWidth + 1 > maxWidth) maxWidth <= curWidth + 1;
      end else begin
        curWidth <= 0;
      end
      if (sdaPullDown != prevSdaPd && sclLine) sdaBadChanges <= sdaBadChanges + 1;
      prevSdaPd <= sdaPullDown;
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sclHigh();
    sclM = 1'b1;
    @(negedge clk);
    while (!sclLine) @(negedge clk);
  endtask

  task automatic startCond();
    sdaM = 1'b1; waitc(HALF / 2);
    sclHigh();   waitc(HALF);
    sdaM = 1'b0; waitc(HALF);
    sclM = 1'b0; waitc(HALF / 2);
  endtask

  task automatic stopCond();
    sclM = 1'b0; waitc(HALF / 2);
    sdaM = 1'b0; waitc(HALF / 2);
    sclHigh();   waitc(HALF);
    sdaM = 1'b1; waitc(HALF);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    sclM = 1'b0; waitc(HALF / 2);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; waitc(HALF / 2);
      sclHigh();   waitc(HALF);
      sclM = 1'b0; waitc(HALF / 2);
    end
    sdaM = 1'b1; waitc(HALF / 2);
    sclHigh();   waitc(HALF / 2);
    acked = !sdaLine;
    waitc(HALF / 2);
    sclM = 1'b0; waitc(HALF / 2);
  endtask

  task automatic testReset();
    check(sdaPullDown == 1'b0, "R1 sdaPullDown", sdaPullDown, 0);
    check(sclPullDown == 1'b0, "R1 sclPullDown", sclPullDown, 0);
    check(rxValid == 1'b0 && rxFirst == 1'b0, "R1 rxValid/rxFirst", rxValid, 0);
    check(subAddr == 3'b101, "R10 subAddr", subAddr, 5);
    subAddrStrap = 3'b010; #1;
    check(subAddr == 3'b010, "R10 subAddr follow", subAddr, 2);
  endtask

  task automatic testWrite();
    logic ack;
    int base = gotCount;
    selStrap = 1'b0;
    startCond();
    sendByte(8'h70, ack); check(ack, "R2 address 0x38 ack", ack, 1);
    sendByte(8'hA5, ack); check(ack, "R5 data ack 0", ack, 1);
    sendByte(8'h3C, ack); check(ack, "R5 data ack 1", ack, 1);
    stopCond();
    check(gotCount - base == 2, "R5 byte count", gotCount - base, 2);
    check(gotData[base] == 8'hA5, "R5 byte0 msb-first", gotData[base], 8'hA5);
    check(gotData[base+1] == 8'h3C, "R5 byte1", gotData[base+1], 8'h3C);
    check(gotFirst[base] == 1'b1, "R6 first flag set", gotFirst[base], 1);
    check(gotFirst[base+1] == 1'b0, "R6 first flag clear", gotFirst[base+1], 0);
    check(maxWidth == 1, "R5 strobe width", maxWidth, 1);
  endtask

  task automatic testStrap();
    logic ack;
    int base;
    selStrap = 1'b1;
    startCond();
    sendByte(8'h72, ack); check(ack, "R2 address 0x39 ack with strap", ack, 1);
    stopCond();
    base = gotCount;
    startCond();
    sendByte(8'h70, ack); check(!ack, "R3 address 0x38 nack with strap", ack, 0);
    sendByte(8'h5A, ack); check(!ack, "R3 ignored byte nack", ack, 0);
    stopCond();
    check(gotCount == base, "R3 no strobe when ignored", gotCount - base, 0);
    selStrap = 1'b0;
  endtask

  task automatic testRead();
    logic ack;
    int base = gotCount;
    startCond();
    sendByte(8'h71, ack); check(!ack, "R4 read nack", ack, 0);
    sendByte(8'hFF, ack); check(!ack, "R4 following byte nack", ack, 0);
    stopCond();
    check(gotCount == base, "R4 no strobe", gotCount - base, 0);
  endtask

  task automatic testStretch();
    logic ack;
    int base = gotCount;
    startCond();
    sendByte(8'h70, ack); check(ack, "R7 setup ack", ack, 1);
    busy = 1'b1;
    sendByte(8'h11, ack); check(ack, "R7 byte ack", ack, 1);
    check(sclPullDown == 1'b1, "R7 hold asserted", sclPullDown, 1);
    waitc(60);
    check(sclPullDown == 1'b1 && sclLine == 1'b0, "R7 hold kept while busy", sclPullDown, 1);
    busy = 1'b0;
    waitc(4);
    check(sclPullDown == 1'b0, "R7 hold released", sclPullDown, 0);
    sendByte(8'hC3, ack); check(ack, "R7 next byte ack", ack, 1);
    stopCond();
    check(gotCount - base == 2, "R7 no byte lost", gotCount - base, 2);
    check(gotData[base+1] == 8'hC3, "R7 byte after hold", gotData[base+1], 8'hC3);
  endtask

  task automatic testRestart();
    logic ack;
    int base = gotCount;
    startCond();
    sendByte(8'h70, ack);
    sendByte(8'h42, ack);
    startCond();
    sendByte(8'h7E, ack); check(!ack, "R8 restart wrong address nack", ack, 0);
    sendByte(8'h99, ack); check(!ack, "R8 ignored after restart", ack, 0);
    startCond();
    sendByte(8'h70, ack); check(ack, "R8 restart from ignore ack", ack, 1);
    sendByte(8'h24, ack);
    stopCond();
    check(gotCount - base == 2, "R8 byte count", gotCount - base, 2);
    check(gotData[base+1] == 8'h24 && gotFirst[base+1], "R8 first after restart",
          gotFirst[base+1], 1);
  endtask

  task automatic testStop();
    logic ack;
    int base;
    startCond();
    sendByte(8'h70, ack);
    sendByte(8'h0F, ack);
    stopCond();
    base = gotCount;
    sendByte(8'h70, ack); check(!ack, "R9 no ack after stop", ack, 0);
    sendByte(8'h55, ack); check(!ack, "R9 data ignored after stop", ack, 0);
    check(gotCount == base, "R9 no strobe after stop", gotCount - base, 0);
    stopCond();
  endtask

  initial begin : watchdog
    for (int i = 0; i < WATCHDOG; i++) begin
      @(posedge clk);
      if (finished) disable watchdog;
    end
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    waitc(5);
    rstN = 1'b1;
    waitc(5);
    testReset();
    testWrite();
    testStrap();
    testRead();
    testStretch();
    testRestart();
    testStop();
    check(sdaBadChanges == 0, "R11 SDA drive only with SCL low", sdaBadChanges, 0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule